// File: doc/BRIEF.md
# Thread-Partitioned Shared Queue

This block is a small in-order buffer that two hardware threads share. Each thread has its own push port with a valid/ready handshake. The consumer side has one output lane that carries an entry together with the ID of the thread it belongs to. A per-thread `popEn` input tells the queue whether the consumer can take an entry for that thread in the current cycle.

When both threads run, the storage is split hard down the middle. Each thread owns one half, so a thread whose consumer is stalled can fill only its own half and never blocks the other thread. When a single thread runs, the halves are joined and that thread can use every slot.

A repartition always waits until the buffer is empty. While the requested mode differs from the mode in force, `modeBusy` stays high and new pushes are held off.

Top module: `tpq_queue`

## Requirements
- R1: During and right after reset, both `empty` bits are 1, both `full` bits are 0, `popValid`, `modeBusy` and `pushErr` are 0, and the mode in force is dual-thread.
- R2: `modeReq` encoding: 0 selects dual-thread, 1 selects thread 0 alone, 2 selects thread 1 alone, and 3 is treated as 0. In dual-thread mode each thread holds at most DEPTH/2 entries. `full[t]` is 1 exactly when thread t holds DEPTH/2.
- R3: `pushReady[t]` is 1 exactly when thread t is active, not full and `modeBusy` is 0. A push is taken at the clock edge when both `pushValid[t]` and `pushReady[t]` are 1. The occupancy of one thread has no effect on the other thread's readiness.
- R4: In a single-thread mode the active thread may hold DEPTH entries, and its `full` bit rises only at DEPTH. The inactive thread shows `full`=1, `empty`=1 and `pushReady`=0.
- R5: For each thread, entries leave in the order they were pushed. `popData` is the oldest entry of the thread named by `popThread`, and the entry is removed at the clock edge.
- R6: A thread is eligible when `popEn[t]` is 1 and it holds data. When both threads are eligible, the grant alternates between them cycle by cycle. After reset the first such grant goes to thread 0.
- R7: When exactly one thread is eligible, it is granted in that same cycle (`popValid`=1). When neither thread is eligible, `popValid` is 0.
- R8: A change of `modeReq` takes effect at the first clock edge at which both threads hold no entries. Until then `modeBusy` is 1.
- R9: In a single-thread mode, a `pushValid` on the inactive thread stores nothing and sets `pushErr` to 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeReq | input | 2 | Requested mode: 0 dual, 1 thread 0 only, 2 thread 1 only, 3 as 0 |
| pushValid | input | 2 | Push request per thread |
| pushData0 | input | DATA_W | Push payload of thread 0 |
| pushData1 | input | DATA_W | Push payload of thread 1 |
| pushReady | output | 2 | Push acceptance per thread |
| popEn | input | 2 | Consumer can take an entry for the thread this cycle |
| popValid | output | 1 | An entry is delivered this cycle |
| popThread | output | 1 | Thread ID of the delivered entry |
| popData | output | DATA_W | Delivered entry |
| full | output | 2 | Thread has reached its current limit |
| empty | output | 2 | Thread holds no entries |
| modeBusy | output | 1 | A requested mode is waiting for the buffer to drain |
| pushErr | output | 1 | One-cycle pulse after a push to the inactive thread |

## Verification
A miscounted occupancy shows up at the ports in one of two ways. `full` or `pushReady` flips at the wrong fill level in the very cycle the count goes wrong, or `popValid` stays high on an empty thread. A wrong read or write pointer, or a region base left stale after a repartition, shows up in the same cycle as a wrong `popData` value for the oldest entry. A wrong rotation bit shows up as `popThread` repeating instead of alternating, the first time both threads are eligible together. A mode switch taken early shows up as `modeBusy` dropping while data is still queued.

// File: rtl/tpq_pkg.sv
package tpq_pkg;

  typedef enum logic [1:0] {
    MODE_MT  = 2'd0,
    MODE_ST0 = 2'd1,
    MODE_ST1 = 2'd2
  } modeT;

  // Strobes from control to storage for one cycle.
  typedef struct packed {
    logic [1:0] wrEn;
    logic       rdEn;
    logic       rdThread;
  } strobeT;

  // Encoding 3 falls back to dual-thread operation.
  function automatic modeT normMode(input logic [1:0] m);
    case (m)
      2'd1:    return MODE_ST0;
      2'd2:    return MODE_ST1;
      default: return MODE_MT;
    endcase
  endfunction

endpackage

// File: rtl/tpq_ctrl.sv
module tpq_ctrl
  import tpq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeReq,
  input  logic [1:0]          pushValid,
  input  logic [1:0]          popEn,
  output logic [1:0]          pushReady,
  output logic                popValid,
  output logic                popThread,
  output logic [1:0]          full,
  output logic [1:0]          empty,
  output logic                modeBusy,
  output logic                pushErr,
  output strobeT              strobe,
  output logic [1:0][AW-1:0]  wrAddr,
  output logic [AW-1:0]       rdAddr
);

  localparam int unsigned HALF = DEPTH / 2;

  modeT            curMode;
  modeT            reqMode;
  logic [CW-1:0]   cnt     [2];
  logic [CW-1:0]   limit   [2];
  logic [AW-1:0]   head    [2];
  logic [AW-1:0]   tail    [2];
  logic [AW-1:0]   lowPtr  [2];
  logic [AW-1:0]   highPtr [2];
  logic [AW-1:0]   newLow  [2];
  logic [1:0]      isActive;
  logic [1:0]      doPush;
  logic [1:0]      doPop;
  logic [1:0]      elig;
  logic            grantT;
  logic            lastGrant;
  logic            applyMode;

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p,
                                            input logic [AW-1:0] lo,
                                            input logic [AW-1:0] hi);
    return (p == hi) ? lo : p + AW'(1);
  endfunction

  assign reqMode  = normMode(modeReq);
  assign modeBusy = (reqMode != curMode);

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      isActive[t] = (curMode == MODE_MT) ||
                    (curMode == MODE_ST0 && t == 0) ||
                    (curMode == MODE_ST1 && t == 1);
      if (curMode == MODE_MT) begin
        limit[t]   = CW'(HALF);
        lowPtr[t]  = AW'(t * HALF);
        highPtr[t] = AW'(t * HALF + HALF - 1);
      end else begin
        limit[t]   = isActive[t] ? CW'(DEPTH) : '0;
        lowPtr[t]  = '0;
        highPtr[t] = AW'(DEPTH - 1);
      end
      newLow[t]    = (reqMode == MODE_MT) ? AW'(t * HALF) : '0;
      full[t]      = (cnt[t] == limit[t]);
      empty[t]     = (cnt[t] == '0);
      pushReady[t] = isActive[t] && !full[t] && !modeBusy;
      doPush[t]    = pushValid[t] && pushReady[t];
      elig[t]      = popEn[t] && !empty[t];
    end
  end

  // Rotate when both threads can be served, otherwise serve the one that can.
  assign grantT    = (elig == 2'b11) ? ~lastGrant : elig[1];
  assign popValid  = |elig;
  assign popThread = grantT;
  assign doPop[0]  = popValid && !grantT;
  assign doPop[1]  = popValid && grantT;
  assign applyMode = modeBusy && (cnt[0] == '0) && (cnt[1] == '0);

  assign strobe.wrEn     = doPush;
  assign strobe.rdEn     = popValid;
  assign strobe.rdThread = grantT;
  assign wrAddr[0]       = tail[0];
  assign wrAddr[1]       = tail[1];
  assign rdAddr          = head[grantT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode   <= MODE_MT;
      lastGrant <= 1'b1;
      pushErr   <= 1'b0;
      for (int t = 0; t < 2; t++) begin
        cnt[t]  <= '0;
        head[t] <= AW'(t * HALF);
        tail[t] <= AW'(t * HALF);
      end
    end else begin
      pushErr <= (curMode == MODE_ST0 && pushValid[1]) ||
                 (curMode == MODE_ST1 && pushValid[0]);
      if (popValid) lastGrant <= grantT;
      if (applyMode) begin
        curMode <= reqMode;
        for (int t = 0; t < 2; t++) begin
          head[t] <= newLow[t];
          tail[t] <= newLow[t];
        end
      end else begin
        for (int t = 0; t < 2; t++) begin
          if (doPush[t]) tail[t] <= stepPtr(tail[t], lowPtr[t], highPtr[t]);
          if (doPop[t])  head[t] <= stepPtr(head[t], lowPtr[t], highPtr[t]);
          cnt[t] <= cnt[t] + CW'(doPush[t]) - CW'(doPop[t]);
        end
      end
    end
  end

  // Occupancy never passes the limit of the mode in force.
  for (genvar t = 0; t < 2; t++) begin : g_chk
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
      cnt[t] <= limit[t]);
  end

  // R6: two threads eligible on consecutive cycles alternate.
  p_alternate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (elig == 2'b11 && $past(elig == 2'b11)) |-> (popThread != $past(popThread)));

  // R8: the mode in force changes only out of an empty buffer.
  p_mode_change_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != $past(curMode)) |-> $past(cnt[0] == '0 && cnt[1] == '0));

  // R9: the inactive thread never gains entries.
  p_idle_untouched_r9: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_ST0) |-> (cnt[1] == '0));

endmodule

// File: rtl/tpq_data.sv
module tpq_data
  import tpq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  strobe,
  input  logic [1:0][AW-1:0]      wrAddr,
  input  logic [1:0][DATA_W-1:0]  wrData,
  input  logic [AW-1:0]           rdAddr,
  output logic [DATA_W-1:0]       rdData
);

  logic [DATA_W-1:0] mem    [DEPTH];
  logic              tagMem [DEPTH];

  always_ff @(posedge clk) begin
    for (int t = 0; t < 2; t++) begin
      if (strobe.wrEn[t]) begin
        mem[wrAddr[t]]    <= wrData[t];
        tagMem[wrAddr[t]] <= 1'(t);
      end
    end
  end

  assign rdData = mem[rdAddr];

  // R5: the slot read belongs to the thread being served.
  p_tag_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |-> (tagMem[rdAddr] == strobe.rdThread));

  // R3: simultaneous pushes land in distinct slots.
  p_no_addr_clash_r3: assert property (@(posedge clk) disable iff (!rstN)
    (&strobe.wrEn) |-> (wrAddr[0] != wrAddr[1]));

endmodule

// File: rtl/tpq_queue.sv
module tpq_queue
  import tpq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeReq,
  input  logic [1:0]        pushValid,
  input  logic [DATA_W-1:0] pushData0,
  input  logic [DATA_W-1:0] pushData1,
  output logic [1:0]        pushReady,
  input  logic [1:0]        popEn,
  output logic              popValid,
  output logic              popThread,
  output logic [DATA_W-1:0] popData,
  output logic [1:0]        full,
  output logic [1:0]        empty,
  output logic              modeBusy,
  output logic              pushErr
);

  localparam int unsigned AW = $clog2(DEPTH);

  strobeT                 strobe;
  logic [1:0][AW-1:0]     wrAddr;
  logic [AW-1:0]          rdAddr;
  logic [1:0][DATA_W-1:0] wrData;

  assign wrData[0] = pushData0;
  assign wrData[1] = pushData1;

  tpq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeReq   (modeReq),
    .pushValid (pushValid),
    .popEn     (popEn),
    .pushReady (pushReady),
    .popValid  (popValid),
    .popThread (popThread),
    .full      (full),
    .empty     (empty),
    .modeBusy  (modeBusy),
    .pushErr   (pushErr),
    .strobe    (strobe),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr)
  );

  tpq_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (popData)
  );

endmodule

// File: tb/tpq_queue_bench.sv
`timescale 1ns/1ps
module tpq_queue_bench;

  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeReq = 2'd0;
  logic [1:0] pushValid = 2'b00;
  logic [7:0] pushData0 = 8'd0;
  logic [7:0] pushData1 = 8'd0;
  logic [1:0] pushReady;
  logic [1:0] popEn = 2'b00;
  logic       popValid;
  logic       popThread;
  logic [7:0] popData;
  logic [1:0] full;
  logic [1:0] empty;
  logic       modeBusy;
  logic       pushErr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Behavioural reference state.
  logic [7:0] q0[$];
  logic [7:0] q1[$];
  int cm = 0;
  bit lastG = 1;
  bit errExp = 0;

  always #5 clk = ~clk;

  tpq_queue #(.DEPTH(DEPTH), .DATA_W(8)) u_tpq_queue (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .pushValid(pushValid),
    .pushData0(pushData0), .pushData1(pushData1), .pushReady(pushReady),
    .popEn(popEn), .popValid(popValid), .popThread(popThread), .popData(popData),
    .full(full), .empty(empty), .modeBusy(modeBusy), .pushErr(pushErr)
  );

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int lim(int t);
    if (cm == 0) return HALF;
    if ((cm == 1 && t == 0) || (cm == 2 && t == 1)) return DEPTH;
    return 0;
  endfunction

  task automatic step();
    int s0, s1, l0, l1, req;
    bit busy, r0, r1, e0, e1, g, pv;
    string fr;
    #1;
    s0 = q0.size(); s1 = q1.size();
    l0 = lim(0);    l1 = lim(1);
    req  = (modeReq == 2'd3) ? 0 : int'(modeReq);
    busy = (req != cm);
    r0 = (l0 > 0) && (s0 < l0) && !busy;
    r1 = (l1 > 0) && (s1 < l1) && !busy;
    e0 = popEn[0] && (s0 > 0);
    e1 = popEn[1] && (s1 > 0);
    g  = (e0 && e1) ? !lastG : e1;
    pv = e0 || e1;
    fr = (cm == 0) ? "R2" : "R4";
    chk("R3", "pushReady0", int'(pushReady[0]), int'(r0));
    chk("R3", "pushReady1", int'(pushReady[1]), int'(r1));
    chk(fr, "full0", int'(full[0]), int'(s0 == l0));
    chk(fr, "full1", int'(full[1]), int'(s1 == l1));
    chk(fr, "empty0", int'(empty[0]), int'(s0 == 0));
    chk(fr, "empty1", int'(empty[1]), int'(s1 == 0));
    chk("R7", "popValid", int'(popValid), int'(pv));
    chk("R8", "modeBusy", int'(modeBusy), int'(busy));
    chk("R9", "pushErr", int'(pushErr), int'(errExp));
    if (pv) begin
      chk((e0 && e1) ? "R6" : "R7", "popThread", int'(popThread), int'(g));
      chk("R5", "popData", int'(popData), g ? int'(q1[0]) : int'(q0[0]));
    end
    // Advance the reference model.
    errExp = (cm == 1 && pushValid[1]) || (cm == 2 && pushValid[0]);
    if (pv) begin
      if (g) void'(q1.pop_front()); else void'(q0.pop_front());
      lastG = g;
    end
    if (pushValid[0] && r0) q0.push_back(pushData0);
    if (pushValid[1] && r1) q1.push_back(pushData1);
    if (busy && s0 == 0 && s1 == 0) cm = req;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(int n, logic [1:0] pv, logic [1:0] pe, logic [1:0] md);
    repeat (n) begin
      pushValid = pv;
      popEn     = pe;
      modeReq   = md;
      pushData0 = 8'($urandom);
      pushData1 = 8'($urandom);
      step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset empty", int'(empty), 3);
    chk("R1", "reset full", int'(full), 0);
    chk("R1", "reset popValid", int'(popValid), 0);
    chk("R1", "reset modeBusy", int'(modeBusy), 0);
    chk("R1", "reset pushErr", int'(pushErr), 0);
    @(negedge clk);
    rstN = 1'b1;
    // R2/R3: both push, then thread 0 fills its half while thread 1 waits.
    drive(3, 2'b11, 2'b00, 2'd0);
    drive(3, 2'b01, 2'b00, 2'd0);
    drive(2, 2'b10, 2'b00, 2'd0);
    // R7: only thread 1 is drained, thread 0 stays full.
    drive(3, 2'b00, 2'b10, 2'd0);
    // R6: both eligible, with pushes refilling.
    drive(12, 2'b11, 2'b11, 2'd0);
    // R8: request thread 0 alone with data still queued.
    drive(3, 2'b11, 2'b00, 2'd1);
    drive(10, 2'b11, 2'b11, 2'd1);
    // R4/R9: single-thread fill, pushes on the idle thread flag an error.
    drive(10, 2'b11, 2'b00, 2'd1);
    drive(4, 2'b01, 2'b01, 2'd1);
    drive(12, 2'b00, 2'b01, 2'd1);
    // Switch to thread 1 alone, then encoding 3 back to dual mode.
    drive(12, 2'b11, 2'b00, 2'd2);
    drive(12, 2'b00, 2'b11, 2'd2);
    drive(10, 2'b11, 2'b01, 2'd3);
    drive(8, 2'b00, 2'b11, 2'd0);
    // Mixed traffic with occasional repartitions.
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] md;
      md = (i % 200 < 100) ? 2'((i / 200) % 4) : modeReq;
      drive(1, 2'($urandom), ($urandom % 3 == 0) ? 2'b00 : 2'($urandom), md);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule